// File: doc/BRIEF.md
# I2C Completion Event Router

This block sits beside an I2C controller and decides where each byte-complete event goes. One event can raise a CPU interrupt, a transmit DMA request or a receive DMA request. The transmit and receive requests are separate outputs. The controller's current transfer direction picks which one of the two applies. A small write port sets the enable bit for each destination, so software can send an event to the CPU, to the DMA engine, or to both at once.

The block can also raise a second interrupt source, the bus-idle term. It is held high for as long as its enable is set and the bus reports not busy, which happens once a STOP has released the bus. A STOP on its own never interrupts. The bus-idle term only goes away when software clears its enable, or when a new transaction starts and the bus turns busy again. The latched completion flag and the bus-idle term are ORed onto one interrupt line.

Each DMA request stays high from its event until the matching acknowledge strobe arrives.

Top module: `i2cEventRouter`

## Requirements
- R1: Out of reset the interrupt enable is 1 and the transmit-request, receive-request and bus-idle enables are 0. All three outputs are low. A completion event with no configuration write therefore raises the interrupt.
- R2: A completion event (`xferDone` high for one cycle) sets the completion flag only while the interrupt enable is 1. The `irqOut` output is high from the cycle after the event while the flag is set and the interrupt enable is 1.
- R3: Writing address 1 with data bit 0 set clears the completion flag one cycle later. If a completion event arrives in the same cycle as the clear, the event wins and the flag stays set.
- R4: A completion event with `txMode`=1 (master or slave transmit) and the transmit-request enable set raises `txDmaReq` in the next cycle. It never raises `rxDmaReq`.
- R5: A completion event with `txMode`=0 (master or slave receive) and the receive-request enable set raises `rxDmaReq` in the next cycle. It never raises `txDmaReq`.
- R6: When several destinations are enabled, a single completion event raises all of the enabled ones in the same cycle.
- R7: A DMA request stays high until its acknowledge (`txAck` or `rxAck`) is sampled high, and it is low in the next cycle. If a new event for the same channel arrives in the same cycle as the acknowledge, the request stays high.
- R8: While the bus-idle enable is 1 and `busBusy` is 0, `irqOut` is high from the next cycle on, for as long as both conditions hold.
- R9: The bus-idle term drops one cycle after either the bus-idle enable is written to 0, `busBusy` is high, or `txnStart` pulses.
- R10: With the bus-idle enable at 0, the bus going from busy to idle (a STOP) never raises `irqOut`.
- R11: A write to address 0 loads the enables from data bits [3:0]: bit 0 interrupt, bit 1 transmit request, bit 2 receive request, bit 3 bus idle. The new values take effect for events in the next cycle and later. For the bus-idle term they already count in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferDone | input | 1 | Byte-complete event pulse from the controller |
| txMode | input | 1 | 1 = controller transmitting, 0 = receiving |
| busBusy | input | 1 | Bus busy status (low after STOP) |
| txnStart | input | 1 | Pulse at the start of a new transaction |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = enable register, 1 = flag clear |
| regWdata | input | DATA_W | Write data |
| txAck | input | 1 | Transmit DMA acknowledge strobe |
| rxAck | input | 1 | Receive DMA acknowledge strobe |
| irqOut | output | 1 | CPU interrupt (completion flag OR bus-idle term) |
| txDmaReq | output | 1 | Transmit DMA request |
| rxDmaReq | output | 1 | Receive DMA request |

## Verification
Directed sequences first drive a completion event in each direction with each enable set alone. They then drive it with several enables set together. Together these show whether the direction flag steers correctly and whether enables leak between destinations. Collision patterns put an event and an acknowledge in the same cycle, and an event and a flag clear in the same cycle; these separate set-priority from clear-priority. Bus-status patterns show that a STOP without the bus-idle enable stays silent, and that the enabled bus-idle term holds as a level. They also show which of the three clearing conditions releases it. A long random phase then mixes all inputs against a cycle model kept in the bench.

// File: rtl/i2cRoutePkg.sv
package i2cRoutePkg;
  localparam int EN_IRQ   = 0;
  localparam int EN_TX    = 1;
  localparam int EN_RX    = 2;
  localparam int EN_IDLE  = 3;
  localparam int EN_W     = 4;
  localparam int CLR_DONE = 0;
  localparam int NUM_CH   = 2;
  localparam int CH_TX    = 0;
  localparam int CH_RX    = 1;

  typedef struct packed {
    logic irqEn;
    logic txEn;
    logic rxEn;
    logic idleEn;
  } routeEn_t;

  typedef struct packed {
    logic              wrCfg;
    logic [EN_W-1:0]   cfgVal;
    logic              setDone;
    logic              clrDone;
    logic [NUM_CH-1:0] setReq;
    logic [NUM_CH-1:0] ackReq;
    logic              idleNext;
  } routeStrobes_t;
endpackage

// File: rtl/i2cRouteCtrl.sv
module i2cRouteCtrl
  import i2cRoutePkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              xferDone,
  input  logic              txMode,
  input  logic              busBusy,
  input  logic              txnStart,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              txAck,
  input  logic              rxAck,
  input  routeEn_t          enQ,
  output routeStrobes_t     strb
);
  logic cfgWrite;
  logic clrWrite;
  logic idleEnNext;

  always_comb begin
    cfgWrite = regWe && (regAddr == 1'b0);
    clrWrite = regWe && (regAddr == 1'b1);
    idleEnNext = cfgWrite ? regWdata[EN_IDLE] : enQ.idleEn;

    strb = '0;
    strb.wrCfg   = cfgWrite;
    strb.cfgVal  = regWdata[EN_W-1:0];
    // completion flag is armed only by an enabled event
    strb.setDone = xferDone && enQ.irqEn;
    strb.clrDone = clrWrite && regWdata[CLR_DONE];
    // direction picks exactly one DMA channel
    strb.setReq[CH_TX] = xferDone && txMode && enQ.txEn;
    strb.setReq[CH_RX] = xferDone && !txMode && enQ.rxEn;
    strb.ackReq[CH_TX] = txAck;
    strb.ackReq[CH_RX] = rxAck;
    // idle level: enabled, bus free and no transaction starting
    strb.idleNext = idleEnNext && !busBusy && !txnStart;
  end
endmodule

// File: rtl/i2cRouteData.sv
module i2cRouteData
  import i2cRoutePkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  routeStrobes_t strb,
  input  logic          busBusy,
  input  logic          txnStart,
  output routeEn_t      enQ,
  output logic          irqOut,
  output logic [NUM_CH-1:0] reqQ
);
  logic doneQ;
  logic idleQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ.irqEn  <= 1'b1;
      enQ.txEn   <= 1'b0;
      enQ.rxEn   <= 1'b0;
      enQ.idleEn <= 1'b0;
    end else if (strb.wrCfg) begin
      enQ.irqEn  <= strb.cfgVal[EN_IRQ];
      enQ.txEn   <= strb.cfgVal[EN_TX];
      enQ.rxEn   <= strb.cfgVal[EN_RX];
      enQ.idleEn <= strb.cfgVal[EN_IDLE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ <= 1'b0;
    end else if (strb.setDone) begin
      doneQ <= 1'b1;
    end else if (strb.clrDone) begin
      doneQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) idleQ <= 1'b0;
    else       idleQ <= strb.idleNext;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gReq
    always_ff @(posedge clk) begin
      if (!rstN)                 reqQ[ch] <= 1'b0;
      else if (strb.setReq[ch])  reqQ[ch] <= 1'b1;
      else if (strb.ackReq[ch])  reqQ[ch] <= 1'b0;
    end

    // R7: an acknowledge without a new event drops the request
    a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ackReq[ch] && !strb.setReq[ch]) |=> !reqQ[ch]);
    // R7: a raised request holds until acknowledged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
      (reqQ[ch] && !strb.ackReq[ch]) |=> reqQ[ch]);
  end

  assign irqOut = (doneQ && enQ.irqEn) || idleQ;

  // R4, R5: direction steers the event to one channel only
  a_r4_one_channel: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(reqQ[CH_TX]) && $rose(reqQ[CH_RX])));
  // R3: a clear without a coincident set empties the flag
  a_r3_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrDone && !strb.setDone) |=> !doneQ);
  // R9: a busy bus or a starting transaction kills the idle term
  a_r9_busy_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy || txnStart) |=> !idleQ);
  // R2: the flag cannot rise without an enabled event
  a_r2_flag_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(strb.setDone));
endmodule

// File: rtl/i2cEventRouter.sv
module i2cEventRouter
  import i2cRoutePkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferDone,
  input  logic              txMode,
  input  logic              busBusy,
  input  logic              txnStart,
  input  logic              regWe,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              txAck,
  input  logic              rxAck,
  output logic              irqOut,
  output logic              txDmaReq,
  output logic              rxDmaReq
);
  routeEn_t          enQ;
  routeStrobes_t     strb;
  logic [NUM_CH-1:0] reqQ;

  i2cRouteCtrl #(.DATA_W(DATA_W)) uCtrl (
    .xferDone (xferDone),
    .txMode   (txMode),
    .busBusy  (busBusy),
    .txnStart (txnStart),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .txAck    (txAck),
    .rxAck    (rxAck),
    .enQ      (enQ),
    .strb     (strb)
  );

  i2cRouteData uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busBusy  (busBusy),
    .txnStart (txnStart),
    .enQ      (enQ),
    .irqOut   (irqOut),
    .reqQ     (reqQ)
  );

  assign txDmaReq = reqQ[CH_TX];
  assign rxDmaReq = reqQ[CH_RX];

  // R4: a transmit request rises only from a transmit-direction event
  a_r4_tx_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDmaReq) |-> $past(xferDone && txMode));
  // R5: a receive request rises only from a receive-direction event
  a_r5_rx_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDmaReq) |-> $past(xferDone && !txMode));
endmodule

// File: tb/tb_i2cEventRouter.sv
module tb_i2cEventRouter;
  logic clk = 1'b0;
  logic rstN;
  logic xferDone, txMode, busBusy, txnStart, regWe, regAddr;
  logic [3:0] regWdata;
  logic txAck, rxAck;
  logic irqOut, txDmaReq, rxDmaReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  bit mIrqEn, mTxEn, mRxEn, mIdleEn, mDone, mTx, mRx, mIdle;

  always #2.5 clk = ~clk;

  i2cEventRouter dut (
    .clk(clk), .rstN(rstN), .xferDone(xferDone), .txMode(txMode),
    .busBusy(busBusy), .txnStart(txnStart), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .txAck(txAck), .rxAck(rxAck),
    .irqOut(irqOut), .txDmaReq(txDmaReq), .rxDmaReq(rxDmaReq)
  );

  function automatic bit expIrq();
    return (mDone && mIrqEn) || mIdle;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, "irqOut", irqOut, expIrq());
    check(tag, "txDmaReq", txDmaReq, mTx);
    check(tag, "rxDmaReq", rxDmaReq, mRx);
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic step(input bit xd, input bit tm, input bit bb, input bit ts,
                      input bit we, input bit ad, input bit [3:0] wd,
                      input bit ta, input bit ra, input string tag);
    bit cfgW, clrW, nIdleEn;
    xferDone = xd; txMode = tm; busBusy = bb; txnStart = ts;
    regWe = we; regAddr = ad; regWdata = wd; txAck = ta; rxAck = ra;
    cfgW = we && !ad;
    clrW = we && ad && wd[0];
    nIdleEn = cfgW ? wd[3] : mIdleEn;
    mIdle = nIdleEn && !bb && !ts;
    if (xd && mIrqEn) mDone = 1;
    else if (clrW) mDone = 0;
    if (xd && tm && mTxEn) mTx = 1; else if (ta) mTx = 0;
    if (xd && !tm && mRxEn) mRx = 1; else if (ra) mRx = 0;
    if (cfgW) begin
      mIrqEn = wd[0]; mTxEn = wd[1]; mRxEn = wd[2]; mIdleEn = wd[3];
    end
    @(posedge clk);
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic idle(input bit bb, input string tag);
    step(0, 0, bb, 0, 0, 0, 4'h0, 0, 0, tag);
  endtask

  task automatic cfg(input bit [3:0] v, input bit bb, input string tag);
    step(0, 0, bb, 0, 1, 0, v, 0, 0, tag);
  endtask

  task automatic finish();
    if (finished) return;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    rstN = 0;
    xferDone = 0; txMode = 0; busBusy = 1; txnStart = 0;
    regWe = 0; regAddr = 0; regWdata = 0; txAck = 0; rxAck = 0;
    mIrqEn = 1; mTxEn = 0; mRxEn = 0; mIdleEn = 0;
    mDone = 0; mTx = 0; mRx = 0; mIdle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    checkAll("R1");

    // R1: default interrupt enable routes an event to the CPU only
    step(1, 1, 1, 0, 0, 0, 4'h0, 0, 0, "R1");
    check("R1", "irq default", irqOut, 1'b1);
    check("R1", "tx default", txDmaReq, 1'b0);
    idle(1, "R2");
    // R3: write-one-to-clear
    step(0, 0, 1, 0, 1, 1, 4'h1, 0, 0, "R3");
    check("R3", "cleared", irqOut, 1'b0);
    // R11 + R6: interrupt and both DMA enables
    cfg(4'b0111, 1, "R11");
    step(1, 1, 1, 0, 0, 0, 4'h0, 0, 0, "R6");
    check("R6", "irq with tx", irqOut, 1'b1);
    check("R6", "tx with irq", txDmaReq, 1'b1);
    check("R5", "rx quiet in tx", rxDmaReq, 1'b0);
    repeat (3) idle(1, "R7");
    check("R7", "tx held", txDmaReq, 1'b1);
    step(0, 0, 1, 0, 0, 0, 4'h0, 1, 0, "R7");
    check("R7", "tx dropped", txDmaReq, 1'b0);
    // R5: receive direction
    step(1, 0, 1, 0, 0, 0, 4'h0, 0, 0, "R5");
    check("R5", "rx raised", rxDmaReq, 1'b1);
    check("R4", "tx quiet in rx", txDmaReq, 1'b0);
    // R7: event and ack collide
    step(1, 0, 1, 0, 0, 0, 4'h0, 0, 1, "R7");
    check("R7", "rx set wins", rxDmaReq, 1'b1);
    step(0, 0, 1, 0, 0, 0, 4'h0, 0, 1, "R7");
    // R3: set and clear collide
    step(1, 0, 1, 0, 1, 1, 4'h1, 0, 1, "R3");
    check("R3", "set wins", irqOut, 1'b1);
    step(0, 0, 1, 0, 1, 1, 4'h1, 0, 1, "R3");
    // R2: interrupt disabled
    cfg(4'b0110, 1, "R2");
    step(1, 1, 1, 0, 0, 0, 4'h0, 0, 0, "R2");
    check("R2", "masked", irqOut, 1'b0);
    step(0, 0, 1, 0, 0, 0, 4'h0, 1, 0, "R7");
    // R4: tx enable off
    cfg(4'b0101, 1, "R11");
    step(1, 1, 1, 0, 0, 0, 4'h0, 0, 0, "R4");
    check("R4", "tx gated", txDmaReq, 1'b0);
    step(0, 0, 1, 0, 1, 1, 4'h1, 0, 0, "R3");
    // R10: STOP without idle enable
    repeat (4) idle(0, "R10");
    check("R10", "stop silent", irqOut, 1'b0);
    // R8: idle level
    cfg(4'b1000, 0, "R11");
    check("R11", "idle takes effect", irqOut, 1'b1);
    repeat (5) idle(0, "R8");
    check("R8", "idle held", irqOut, 1'b1);
    // R9: clearing conditions
    idle(1, "R9");
    check("R9", "busy clears", irqOut, 1'b0);
    idle(0, "R8");
    step(0, 0, 0, 1, 0, 0, 4'h0, 0, 0, "R9");
    check("R9", "start clears", irqOut, 1'b0);
    idle(0, "R8");
    check("R8", "idle again", irqOut, 1'b1);
    cfg(4'b0001, 0, "R9");
    check("R9", "enable clear", irqOut, 1'b0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[2], r[3] | r[4], (r[5:7] == 3'b000), (r[8:11] == 4'h0),
           r[12], r[16:13], r[17] & r[18], r[19] & r[20],
           (i % 3 == 0) ? "R2" : ((i % 3 == 1) ? "R4" : "R5"));
    end
    finish();
  end

  initial begin
    void'($urandom(32'd12345));
  end
endmodule